// File: doc/BRIEF.md
# Filtered Edge-Selectable Input Capture

This block watches an asynchronous capture pin and, when the chosen edge occurs, copies the current value of a free-running 16-bit counter into a capture register. The counter lives outside the block and reaches it through a port. An edge-select input chooses between the rising edge and the falling edge. A filter-enable input switches on a digital noise filter. When the filter is on, the pin has to hold its new level for several system-clock samples before that level counts.

The pin first goes through a two-flop synchronizer. A level tracker then forms a clean pin level. With the filter off, this level follows the synchronized pin on every cycle. With the filter on, it changes only after four consecutive samples agree on the new level. An edge is a change of this tracked level. For that reason, a level that is held produces exactly one capture, and changing the edge-select input does nothing until the tracked level moves. A capture-event strobe stays high for one clock alongside each update of the capture register.

Top module: `capture_unit`

## Requirements
- R1: After a synchronous reset, the capture register reads 0 and the capture strobe is low.
- R2: With the filter off, a pin change that is held for at least one clock gives a capture at the third rising clock edge after the change. The pin passes through a two-flop synchronizer, and the pin is sampled on every clock.
- R3: With the filter on, the tracked level changes only once four consecutive synchronized samples agree on the new level. A change held for four or more clocks gives a capture at the sixth clock edge after the change. A pulse shorter than four clocks gives no capture.
- R4: With edge_rise = 1, only a low-to-high change of the tracked level gives a capture.
- R5: With edge_rise = 0, only a high-to-low change of the tracked level gives a capture.
- R6: On a capture, the capture register takes the full 16-bit value that count_in holds at the capturing clock edge.
- R7: The capture strobe is high for exactly one clock for each capture. The capture register does not change on any cycle without a capture.
- R8: A level held for any length of time gives at most one capture.
- R9: Changing edge_rise or filt_en while the pin is steady gives no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Raw asynchronous capture pin |
| count_in | input | 16 | Counter value to capture |
| filt_en | input | 1 | 1 = four-sample noise filter on |
| edge_rise | input | 1 | 1 = capture on rising edge, 0 = capture on falling edge |
| cap_value | output | 16 | Capture register |
| cap_strobe | output | 1 | One-clock pulse on each capture |

## Verification
The main test sends single high pulses from one to six clocks wide out of a low idle level. It covers every pairing of filter on or off with rising or falling edge select. The unfiltered runs pin down the three-cycle synchronizer latency. In the falling-edge runs, the capture moves with the pulse width, which separates the leading edge from the trailing edge. With the filter on, the widths just below and at four clocks separate a glitch that is rejected from an edge that is accepted, and they also show the later acceptance point. The counter input carries an arithmetic sequence, so a value captured one cycle early or late shows up as a wrong value. A separate run holds the pin high while edge_rise toggles, to show that the select input alone never produces a capture.

// File: rtl/capture_pkg.sv
package capture_pkg;
  localparam int CAP_CNT_W    = 16;
  localparam int CAP_SYNC_LEN = 2;
  localparam int CAP_FILT_LEN = 4;
endpackage

// File: rtl/capture_sync.sv
module capture_sync #(
  parameter int STAGES = capture_pkg::CAP_SYNC_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/capture_filter.sv
module capture_filter #(
  parameter int FILT_LEN = capture_pkg::CAP_FILT_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic filt_en,
  input  logic s_in,
  output logic lvl_q,
  output logic lvl_d
);
  localparam int HW = FILT_LEN - 1;

  logic [HW-1:0] hist;
  logic all_hi, all_lo;

  assign all_hi = s_in & (&hist);
  assign all_lo = ~s_in & ~(|hist);

  always_comb begin
    if (!filt_en)    lvl_d = s_in;
    else if (all_hi) lvl_d = 1'b1;
    else if (all_lo) lvl_d = 1'b0;
    else             lvl_d = lvl_q;
  end

  generate
    if (HW > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[HW-2:0], s_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= s_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_d;
  end
endmodule

// File: rtl/capture_latch.sv
module capture_latch #(
  parameter int CNT_W = capture_pkg::CAP_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_q,
  input  logic             lvl_d,
  input  logic             edge_rise,
  input  logic [CNT_W-1:0] count_in,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_strobe
);
  logic hit;

  // a change of tracked level whose new value matches the selected edge
  assign hit = (lvl_d != lvl_q) && (lvl_d == edge_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value  <= '0;
      cap_strobe <= 1'b0;
    end else begin
      cap_strobe <= hit;
      if (hit) cap_value <= count_in;
    end
  end
endmodule

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int CNT_W    = capture_pkg::CAP_CNT_W,
  parameter int SYNC_LEN = capture_pkg::CAP_SYNC_LEN,
  parameter int FILT_LEN = capture_pkg::CAP_FILT_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] count_in,
  input  logic             filt_en,
  input  logic             edge_rise,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_strobe
);
  logic sync_s;
  logic lvl_q, lvl_d;

  capture_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d_async(cap_pin), .d_sync(sync_s)
  );

  capture_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .filt_en(filt_en), .s_in(sync_s),
    .lvl_q(lvl_q), .lvl_d(lvl_d)
  );

  capture_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .lvl_q(lvl_q), .lvl_d(lvl_d),
    .edge_rise(edge_rise), .count_in(count_in),
    .cap_value(cap_value), .cap_strobe(cap_strobe)
  );
endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
  parameter int CNT_W = capture_pkg::CAP_CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             filt_en,
  input logic             edge_rise,
  input logic [CNT_W-1:0] count_in,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_strobe,
  input logic             sync_s,
  input logic             lvl
);
  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cap_value == '0) && !cap_strobe);

  // R7: strobe never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |=> !cap_strobe);

  // R7: register holds when no capture happens
  a_r7_hold_value: assert property (@(posedge clk) disable iff (rst)
    (!cap_strobe && !$past(rst)) |-> $stable(cap_value));

  // R6: captured value is the counter at the capturing edge
  a_r6_full_value: assert property (@(posedge clk) disable iff (rst)
    (cap_strobe && !$past(rst)) |-> cap_value == $past(count_in));

  // R4 / R5: capture only on a tracked-level change toward the chosen edge
  a_r4_r5_edge_dir: assert property (@(posedge clk) disable iff (rst)
    (cap_strobe && !$past(rst)) |-> (lvl == $past(edge_rise)) && (lvl != $past(lvl)));

  // R3: a filtered level change is backed by agreeing synchronized samples
  a_r3_filter_agree: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_en) && !$past(rst) && (lvl != $past(lvl)))
      |-> ($past(sync_s, 1) == lvl) && ($past(sync_s, 2) == lvl));
endmodule

bind capture_unit capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .filt_en(filt_en), .edge_rise(edge_rise),
  .count_in(count_in), .cap_value(cap_value), .cap_strobe(cap_strobe),
  .sync_s(sync_s), .lvl(lvl_q)
);

// File: tb/sim_capture_unit.sv
`timescale 1ns/1ps
module sim_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin = 1'b0;
  logic        filt_en = 1'b0;
  logic        edge_rise = 1'b1;
  logic [15:0] cyc = 16'd0;
  logic [15:0] count_in;
  logic [15:0] cap_value;
  logic        cap_strobe;

  int total = 0;
  int bad   = 0;
  logic [15:0] cap_exp = 16'd0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 16'd1;
  assign count_in = cyc * 16'd37 + 16'd11;

  capture_unit u0 (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .count_in(count_in),
    .filt_en(filt_en), .edge_rise(edge_rise),
    .cap_value(cap_value), .cap_strobe(cap_strobe)
  );

  function automatic logic [15:0] cnt_at(input logic [15:0] c);
    return c * 16'd37 + 16'd11;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one high pulse of width w from a low idle level
  task automatic run_pulse(input bit fe, input bit es, input int w);
    logic [15:0] c0;
    int e;
    @(negedge clk);
    filt_en = fe; edge_rise = es;
    repeat (10) begin
      @(negedge clk);
      chk(cap_strobe == 1'b0, "R9 idle", cap_strobe, 0);
    end
    if (!fe) e = es ? 3 : w + 3;
    else if (w < 4) e = -1;
    else e = es ? 6 : w + 6;
    c0 = cyc;
    cap_pin = 1'b1;
    for (int i = 1; i <= w + 10; i++) begin
      @(negedge clk);
      if (i == e) begin
        chk(cap_strobe == 1'b1, es ? (fe ? "R3 R4" : "R2 R4") : (fe ? "R3 R5" : "R2 R5"),
            cap_strobe, 1);
        cap_exp = cnt_at(c0 + 16'(e - 1));
        chk(cap_value == cap_exp, "R6", cap_value, cap_exp);
      end else begin
        chk(cap_strobe == 1'b0, fe ? "R3 R7 R8" : "R7 R8", cap_strobe, 0);
        chk(cap_value == cap_exp, "R7", cap_value, cap_exp);
      end
      if (i == w) cap_pin = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cap_value == 16'd0, "R1 value", cap_value, 0);
    chk(cap_strobe == 1'b0, "R1 strobe", cap_strobe, 0);

    for (int fe = 0; fe < 2; fe++)
      for (int es = 0; es < 2; es++)
        for (int w = 1; w <= 6; w++)
          run_pulse(fe[0], es[0], w);

    // R9: hold pin high, toggle edge select and filter, expect nothing
    filt_en = 1'b0; edge_rise = 1'b0;
    cap_pin = 1'b1;
    repeat (8) @(negedge clk);
    chk(cap_value == cap_exp, "R5 no rise", cap_value, cap_exp);
    for (int k = 0; k < 12; k++) begin
      edge_rise = ~edge_rise;
      if (k % 3 == 0) filt_en = ~filt_en;
      @(negedge clk);
      chk(cap_strobe == 1'b0, "R9", cap_strobe, 0);
      chk(cap_value == cap_exp, "R9", cap_value, cap_exp);
    end

    // R1: reset in the middle clears the register
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cap_pin = 1'b0;
    cap_exp = 16'd0;
    @(negedge clk);
    chk(cap_value == 16'd0, "R1 mid", cap_value, 0);
    chk(cap_strobe == 1'b0, "R1 mid", cap_strobe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule